// File: doc/BRIEF.md
# Acquisition pacing timer

This block sets the pace of an analog-to-digital acquisition run. It holds two chained 16-bit down-counters. The interval counter is a rate generator: once loaded with a divisor N, it drives an active-low conversion strobe `conv_n`. The strobe falls once every N ticks of the chosen timebase, and the converter starts a conversion on each falling edge, not on the level. The sample counter is loaded with M-1 and counts the falling edges. On the M-th edge it raises a done pulse and a sticky done flag, and it halts the interval counter so that no further conversion starts.

Software programs the block through a byte-wide write port. A control word selects a counter and resets that counter's byte order. Each 16-bit count then follows as two data writes, low byte first. The timebase is either a reference tick or a tick from an auxiliary counter, chosen by a select pin. The `arm` input gates the run.

Top module: `acq_pacer`

## Requirements
- R1: After reset `conv_n` is 1 and `done_pulse` and `done_flag` are 0. With no interval count loaded, `conv_n` never falls, even while `arm` is 1 and ticks arrive.
- R2: Write addresses are 0 for interval data, 1 for sample data and 3 for control. A count is assembled low byte first and takes effect only after its high byte. A control word accepted for a counter resets that counter's byte order, so a low byte written before it is discarded.
- R3: With `arm` at 1 and interval count N (2..65535) loaded, the first falling edge of `conv_n` comes on the (N-1)-th selected tick. Every later falling edge comes exactly N selected ticks after the previous one. `conv_n` stays low until the next selected tick.
- R4: When `tb_sel` is 0 only `tick_ref` counts; when it is 1 only `tick_aux` counts. Pulses on the unselected input have no effect.
- R5: With the sample counter loaded with M-1 (M from 2 to 65535), exactly M falling edges of `conv_n` occur. After the M-th edge `conv_n` returns to 1 on the next selected tick and stays there.
- R6: `done_pulse` is 1 for exactly one cycle, in the same cycle that `conv_n` shows the M-th falling edge. `done_flag` rises then and stays 1 until control word 0x70 is written.
- R7: Control word 0x34 makes `conv_n` 1 on the next cycle and discards the interval count. No falling edge follows until a new count is loaded.
- R8: Only the control values 0x34 (interval counter, rate mode) and 0x70 (sample counter, terminal-count mode) are accepted. Any other control value, and any write to address 2, leaves the strobe timing unchanged.
- R9: While `arm` is 0, `conv_n` is 1 from the next cycle on. When `arm` returns to 1, counting restarts from N, so the first falling edge again comes after N-1 ticks.
- R10: If the sample counter holds no count, the interval counter runs freely and `done_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 interval data, 1 sample data, 3 control |
| wr_data | input | 8 | Write data byte |
| tb_sel | input | 1 | Timebase select: 0 reference tick, 1 auxiliary tick |
| tick_ref | input | 1 | Reference timebase tick, a one-cycle enable |
| tick_aux | input | 1 | Auxiliary timebase tick, a one-cycle enable |
| arm | input | 1 | Run gate for the interval counter |
| conv_n | output | 1 | Active-low conversion strobe; the falling edge starts a conversion |
| done_pulse | output | 1 | One-cycle pulse when the sample count completes |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The assertions assume that both tick inputs are one-cycle enables synchronous to `clk`. They also assume that N and M stay within their legal ranges, since an out-of-range count would wrap the down-counters. The stimulus loads counts only while `arm` is 0 or while no tick is being driven. After each high byte it inserts an idle cycle before ticking resumes, and it draws N and M only from the legal ranges. Random tick densities and random noise on the unselected timebase vary the spacing between ticks without breaking these assumptions.

// File: rtl/acq_pacer_pkg.sv
package acq_pacer_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADDR_IVL = 2'd0,
        ADDR_SMP = 2'd1,
        ADDR_RSV = 2'd2,
        ADDR_CTL = 2'd3
    } addr_e;

    // Layout of a control byte: counter select, byte access, mode, decimal flag.
    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] access;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;

    localparam logic [1:0] SEL_IVL   = 2'b00;
    localparam logic [1:0] SEL_SMP   = 2'b01;
    localparam logic [1:0] ACC_LOHI  = 2'b11;
    localparam logic [2:0] MODE_RATE = 3'd2;
    localparam logic [2:0] MODE_TERM = 3'd0;

    function automatic logic is_ivl_cw(input ctl_word_t w);
        return (w.sel == SEL_IVL) && (w.access == ACC_LOHI) &&
               (w.mode == MODE_RATE) && !w.bcd;
    endfunction

    function automatic logic is_smp_cw(input ctl_word_t w);
        return (w.sel == SEL_SMP) && (w.access == ACC_LOHI) &&
               (w.mode == MODE_TERM) && !w.bcd;
    endfunction

endpackage

// File: rtl/acq_pacer_bytereg.sv
// Assembles a count from byte writes, least significant byte first.
module acq_pacer_bytereg
    import acq_pacer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [7:0]       din,
    output logic             load,
    output logic [CNT_W-1:0] word
);
    localparam int NBYTES = CNT_W / BYTE_W;
    localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] hold;
        logic             load;
        logic [CNT_W-1:0] word;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.load = 1'b0;
        if (clr) begin
            d.idx = '0;
        end else if (wr) begin
            d.hold[int'(q.idx)*BYTE_W +: BYTE_W] = din;
            if (q.idx == IDX_W'(NBYTES-1)) begin
                d.idx  = '0;
                d.load = 1'b1;
                d.word = d.hold;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign load = q.load;
    assign word = q.word;

endmodule

// File: rtl/acq_pacer_rategen.sv
// Rate generator: strobe low for one tick period every N ticks.
module acq_pacer_rategen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             arm,
    input  logic             halt,
    output logic             fire,
    output logic             out_n
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             loaded;
        logic             out_n;
    } st_t;

    st_t q, d;

    always_comb begin
        d    = q;
        fire = 1'b0;
        if (park) begin
            d.out_n  = 1'b1;
            d.loaded = 1'b0;
            d.cnt    = '0;
            d.reload = '0;
        end else if (load) begin
            d.cnt    = load_val;
            d.reload = load_val;
            d.loaded = 1'b1;
            d.out_n  = 1'b1;
        end else if (!arm) begin
            d.out_n = 1'b1;
            d.cnt   = q.reload;
        end else if (halt) begin
            if (tick) d.out_n = 1'b1;
        end else if (q.loaded && tick) begin
            if (q.cnt == CNT_W'(1)) begin
                d.out_n = 1'b1;
                d.cnt   = q.reload;
            end else if (q.cnt == CNT_W'(2)) begin
                d.out_n = 1'b0;
                d.cnt   = CNT_W'(1);
                fire    = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, reload: '0, loaded: 1'b0, out_n: 1'b1};
        else        q <= d;
    end

    assign out_n = q.out_n;

endmodule

// File: rtl/acq_pacer_smpcnt.sv
// Sample counter: counts strobes from M-1 down, halts the pacer on the M-th.
module acq_pacer_smpcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park_smp,
    input  logic             park_ivl,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             strobe,
    output logic             halt,
    output logic             done_pulse,
    output logic             done_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             loaded;
        logic             halt;
        logic             pulse;
        logic             flag;
    } st_t;

    st_t q, d;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (park_smp) begin
            d.loaded = 1'b0;
            d.flag   = 1'b0;
            d.halt   = 1'b0;
            d.cnt    = '0;
        end else begin
            if (park_ivl) d.halt = 1'b0;
            if (load) begin
                d.cnt    = load_val;
                d.loaded = 1'b1;
            end else if (strobe && q.loaded) begin
                if (q.cnt == '0) begin
                    d.loaded = 1'b0;
                    d.halt   = 1'b1;
                    d.flag   = 1'b1;
                    d.pulse  = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign halt       = q.halt;
    assign done_pulse = q.pulse;
    assign done_flag  = q.flag;

endmodule

// File: rtl/acq_pacer.sv
module acq_pacer
    import acq_pacer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       tb_sel,
    input  logic       tick_ref,
    input  logic       tick_aux,
    input  logic       arm,
    output logic       conv_n,
    output logic       done_pulse,
    output logic       done_flag
);
    localparam int NCNT = 2;

    ctl_word_t        cw;
    logic             ctl_wr;
    logic [NCNT-1:0]  park_v;
    logic [NCNT-1:0]  dwr_v;
    logic [NCNT-1:0]  ld_v;
    logic [CNT_W-1:0] word_v [NCNT];
    logic             tick_sel;
    logic             fire;
    logic             smp_halt;

    assign cw       = ctl_word_t'(wr_data);
    assign ctl_wr   = wr_en && (wr_addr == ADDR_CTL);
    assign park_v[0] = ctl_wr && is_ivl_cw(cw);
    assign park_v[1] = ctl_wr && is_smp_cw(cw);
    assign dwr_v[0]  = wr_en && (wr_addr == ADDR_IVL);
    assign dwr_v[1]  = wr_en && (wr_addr == ADDR_SMP);
    assign tick_sel  = tb_sel ? tick_aux : tick_ref;

    for (genvar g = 0; g < NCNT; g++) begin : g_ld
        acq_pacer_bytereg #(.CNT_W(CNT_W)) i_bytereg (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (park_v[g]),
            .wr   (dwr_v[g]),
            .din  (wr_data),
            .load (ld_v[g]),
            .word (word_v[g])
        );
    end

    acq_pacer_rategen #(.CNT_W(CNT_W)) i_rategen (
        .clk     (clk),
        .rst_n   (rst_n),
        .park    (park_v[0]),
        .load    (ld_v[0]),
        .load_val(word_v[0]),
        .tick    (tick_sel),
        .arm     (arm),
        .halt    (smp_halt),
        .fire    (fire),
        .out_n   (conv_n)
    );

    acq_pacer_smpcnt #(.CNT_W(CNT_W)) i_smpcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .park_smp  (park_v[1]),
        .park_ivl  (park_v[0]),
        .load      (ld_v[1]),
        .load_val  (word_v[1]),
        .strobe    (fire),
        .halt      (smp_halt),
        .done_pulse(done_pulse),
        .done_flag (done_flag)
    );

endmodule

// File: rtl/acq_pacer_chk.sv
module acq_pacer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       arm,
    input logic       conv_n,
    input logic       done_pulse,
    input logic       done_flag,
    input logic       halt
);
    logic park_ivl_wr;
    logic park_smp_wr;
    assign park_ivl_wr = wr_en && (wr_addr == 2'd3) && (wr_data == 8'h34);
    assign park_smp_wr = wr_en && (wr_addr == 2'd3) && (wr_data == 8'h70);

    assert_park_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        park_ivl_wr |=> conv_n);

    assert_arm_low_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> conv_n);

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_pulse_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $fell(conv_n));

    assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> done_pulse);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !park_smp_wr) |=> done_flag);

    assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !done_pulse) |-> !$fell(conv_n));

endmodule

bind acq_pacer acq_pacer_chk i_acq_pacer_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .arm       (arm),
    .conv_n    (conv_n),
    .done_pulse(done_pulse),
    .done_flag (done_flag),
    .halt      (smp_halt)
);

// File: tb/test_acq_pacer.sv
module test_acq_pacer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       tb_sel;
    logic       tick_ref;
    logic       tick_aux;
    logic       arm;
    logic       conv_n;
    logic       done_pulse;
    logic       done_flag;

    int  n_chk = 0;
    int  n_fail = 0;
    int  ticks_g = 0;
    int  last_g = 0;
    bit  fell_g = 1'b0;
    bit  prev_conv = 1'b1;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    acq_pacer i_acq_pacer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tb_sel(tb_sel), .tick_ref(tick_ref),
        .tick_aux(tick_aux), .arm(arm), .conv_n(conv_n),
        .done_pulse(done_pulse), .done_flag(done_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive ticks, pass a rising edge, sample at the falling edge.
    task automatic cyc(input bit tr, input bit ta);
        tick_ref = tr;
        tick_aux = ta;
        @(negedge clk);
        if (arm && (tb_sel ? ta : tr)) ticks_g++;
        fell_g    = prev_conv && !conv_n;
        prev_conv = conv_n;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        cyc(1'b0, 1'b0);
        wr_en = 1'b0;
    endtask

    task automatic load_ivl(input int n);
        wr(2'd0, n[7:0]);
        wr(2'd0, n[15:8]);
        cyc(1'b0, 1'b0);
    endtask

    task automatic load_smp(input int m);
        int v = m - 1;
        wr(2'd1, v[7:0]);
        wr(2'd1, v[15:8]);
        cyc(1'b0, 1'b0);
    endtask

    task automatic start();
        arm = 1'b1;
        ticks_g = 0;
        last_g = 0;
    endtask

    // Wait for k falling edges and check the tick distance of each.
    task automatic observe(input int k, input int first_gap, input int gap,
                           input string req, input int pmod);
        for (int e = 0; e < k; e++) begin
            int exp_gap = (e == 0) ? first_gap : gap;
            int cap = 16 * exp_gap * pmod + 64;
            bit seen = 1'b0;
            for (int c = 0; c < cap && !seen; c++) begin
                cyc(($urandom % pmod) == 0, ($urandom % pmod) == 0);
                seen = fell_g;
            end
            check(seen, req, 0, 1);
            check(ticks_g - last_g == exp_gap, req, ticks_g - last_g, exp_gap);
            last_g = ticks_g;
        end
    endtask

    task automatic quiet(input int nticks, input string req);
        int falls = 0;
        int t0 = ticks_g;
        for (int c = 0; c < 8 * nticks + 16 && (ticks_g - t0) < nticks; c++) begin
            cyc(1'b1, 1'b1);
            if (fell_g) falls++;
        end
        check(falls == 0, req, falls, 0);
    endtask

    task automatic run_check(input int n, input int m, input bit sel, input int pmod);
        arm = 1'b0;
        tb_sel = sel;
        wr(2'd3, 8'h34);
        wr(2'd3, 8'h70);
        load_smp(m);
        load_ivl(n);
        check(conv_n == 1'b1, "R7 parked before run", conv_n, 1);
        check(done_flag == 1'b0, "R6 flag clear before run", done_flag, 0);
        start();
        for (int e = 1; e <= m; e++) begin
            observe(1, (e == 1) ? n - 1 : n, n, sel ? "R4 aux spacing" : "R3 spacing", pmod);
            if (e == m) begin
                check(done_pulse == 1'b1, "R6 pulse on last edge", done_pulse, 1);
                check(done_flag == 1'b1, "R6 flag on last edge", done_flag, 1);
            end else begin
                check(done_pulse == 1'b0, "R5 no early done", done_pulse, 0);
            end
        end
        cyc(1'b0, 1'b0);
        check(done_pulse == 1'b0, "R6 pulse one cycle", done_pulse, 0);
        quiet(2 * n + 2, "R5 halted after M");
        check(conv_n == 1'b1, "R5 strobe high after halt", conv_n, 1);
        check(done_flag == 1'b1, "R6 flag sticky", done_flag, 1);
        arm = 1'b0;
        wr(2'd3, 8'h70);
        check(done_flag == 1'b0, "R6 flag cleared by 0x70", done_flag, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        tb_sel = 1'b0; tick_ref = 1'b0; tick_aux = 1'b0; arm = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0);

        // R1: reset state and no strobe without a count
        check(conv_n == 1'b1, "R1 reset conv_n", conv_n, 1);
        check(done_pulse == 1'b0, "R1 reset done_pulse", done_pulse, 0);
        check(done_flag == 1'b0, "R1 reset done_flag", done_flag, 0);
        start();
        quiet(20, "R1 idle without count");
        arm = 1'b0;

        // R2: a low byte alone does not load
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h03);
        cyc(1'b0, 1'b0);
        start();
        quiet(20, "R2 half-written count");
        arm = 1'b0;
        wr(2'd0, 8'h00);
        cyc(1'b0, 1'b0);
        start();
        observe(1, 2, 3, "R2 count after high byte", 1);
        // R10: no sample count, free running
        observe(3, 3, 3, "R10 free run", 1);
        check(done_flag == 1'b0, "R10 no done", done_flag, 0);

        // R2: control word resets byte order
        arm = 1'b0;
        wr(2'd0, 8'h55);
        wr(2'd3, 8'h34);
        load_ivl(4);
        start();
        observe(2, 3, 4, "R2 byte order reset", 1);

        // R8: foreign control values and reserved address ignored
        wr(2'd3, 8'h30);
        wr(2'd3, 8'h74);
        wr(2'd2, 8'h34);
        wr(2'd3, 8'h35);
        wr(2'd3, 8'hB4);
        observe(2, 4, 4, "R8 ignored writes", 1);

        // R7: park mid-run
        wr(2'd3, 8'h34);
        check(conv_n == 1'b1, "R7 park forces high", conv_n, 1);
        quiet(12, "R7 parked quiet");
        load_ivl(5);
        last_g = ticks_g;
        observe(2, 4, 5, "R7 reload after park", 1);

        // R9: arm low while strobe is low
        arm = 1'b0;
        cyc(1'b1, 1'b1);
        check(conv_n == 1'b1, "R9 arm low forces high", conv_n, 1);
        start();
        observe(2, 4, 5, "R9 restart from N", 1);
        arm = 1'b0;

        // R3: largest interval
        wr(2'd3, 8'h34);
        load_ivl(65535);
        start();
        observe(1, 65534, 65535, "R3 max interval", 1);
        arm = 1'b0;

        // R5/R4: minimum counts, both timebases
        run_check(2, 2, 1'b0, 1);
        run_check(2, 2, 1'b1, 3);

        // Random runs
        for (int r = 0; r < 8; r++) begin
            int n = 2 + int'($urandom % 19);
            int m = 2 + int'($urandom % 5);
            bit s = 1'($urandom % 2);
            int p = 1 + int'($urandom % 4);
            run_check(n, m, s, p);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule